// File: doc/BRIEF.md
# Reset and Start-up Sequencer

This block keeps a processor core in reset until the supply and the clock can be trusted. A power-on pulse starts a chain of two delays. First a power-up timer counts ticks of a slow clock-enable. Then an oscillator start-up timer counts oscillator-ready ticks. The core leaves reset only once the whole chain has run. The power-up delay can be switched off by configuration, but that only affects power-on. A qualified supply dip always puts the power-up delay back in front of the oscillator wait.

A brown-out comparator flag reports whether the supply is above the selected trip level. The block passes the 2-bit level selection on to the analog comparator. A dip must last a minimum number of slow ticks before it counts. While the supply is low the block holds reset. When the supply recovers, the power-up timer runs again from zero, and a fresh dip during that time sends the block back into the hold state. An active-low external reset pin is synchronised and gates the release. It never restarts delays that have already finished. Sticky flags record which event caused the most recent reset.

Top module: `rst_seq_top`

## Requirements
- R1: After the synchronous reset `rst`, core reset is high, all three cause flags are 0, and the block waits for a power-on pulse, whatever ticks arrive.
- R2: A power-on pulse restarts the sequence. With `cfg_pwrt_en_i`=1, core reset falls on the clock edge that samples the PWRT_TICKS-th slow tick after the pulse, plus the OST_TICKS-th oscillator tick counted only after that, provided the pin is high.
- R3: With `cfg_pwrt_en_i`=0, a power-on pulse skips the power-up timer, and release follows OST_TICKS oscillator ticks.
- R4: With parameter OST_BYPASS=1 the oscillator wait is skipped: release follows the power-up timer, or comes on the pulse edge itself when that timer is disabled.
- R5: With `cfg_bor_en_i`=1 and the block past the power-up timer, `supply_ok_i`=0 held for BOR_FILT_TICKS slow ticks asserts core reset on the next edge. A dip that ends after fewer ticks is ignored.
- R6: With `cfg_bor_en_i`=0 a low `supply_ok_i` has no effect on core reset or on the flags.
- R7: In brown-out hold, core reset stays high while `supply_ok_i`=0. Once it returns to 1 the power-up timer always runs (even with `cfg_pwrt_en_i`=0), and then the oscillator timer runs.
- R8: A low `supply_ok_i` on any cycle of the power-up timer (with brown-out enabled) returns the block to brown-out hold on the next edge. The timer then starts from zero after the next recovery.
- R9: The external pin passes through two flip-flops. A low pin in run state asserts core reset on the third edge and sets the external flag. A rising pin releases on the third edge, and no timer runs again.
- R10: The delays run from the power-on pulse even while the pin is low. If the pin is held past both delays, release follows on the third edge after it rises.
- R11: The flags are one-hot. A power-on pulse sets the power-on flag and clears the others. Entering brown-out hold sets the brown-out flag and clears the others.
- R12: `trip_sel_o` always equals `cfg_trip_sel_i` (code 0 to 3 selects one of four trip levels).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer registers |
| por_pulse_i | input | 1 | Power-on detect pulse |
| supply_ok_i | input | 1 | Comparator flag, 1 = supply above trip level |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| cfg_pwrt_en_i | input | 1 | Power-up timer enable for power-on |
| cfg_bor_en_i | input | 1 | Brown-out detection enable |
| cfg_trip_sel_i | input | 2 | Trip level selection |
| slow_tick_i | input | 1 | Slow clock-enable for power-up timer and dip filter |
| osc_tick_i | input | 1 | Oscillator-ready tick for the start-up timer |
| core_rst_o | output | 1 | Core reset, high while held |
| trip_sel_o | output | 2 | Trip level code to the comparator |
| stat_por_o | output | 1 | Last reset came from power-on |
| stat_bor_o | output | 1 | Last reset came from brown-out |
| stat_ext_o | output | 1 | Last reset came from the external pin |

## Verification
The hardest case to reach is a supply dip that lands inside the power-up timer after a brown-out recovery. Reaching it takes a qualified dip first, then a recovery, then a few ticks of partial progress, then a second dip of a single cycle. The bench builds that chain one step at a time. It then counts the ticks to release and expects the full power-up length again, not the shortened remainder. A pin held low across a whole power-on sequence is the other hard case: the bench keeps it low for more ticks than both delays need, then times the release to the exact edge.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR_WAIT  = 3'd0,
        ST_BOR_HOLD  = 3'd1,
        ST_PWRT_RUN  = 3'd2,
        ST_OST_RUN   = 3'd3,
        ST_WAIT_MCLR = 3'd4,
        ST_RUN       = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic por;
        logic bor;
        logic ext;
    } rst_cause_t;

    localparam rst_cause_t CAUSE_NONE = '{por: 1'b0, bor: 1'b0, ext: 1'b0};
    localparam rst_cause_t CAUSE_POR  = '{por: 1'b1, bor: 1'b0, ext: 1'b0};
    localparam rst_cause_t CAUSE_BOR  = '{por: 1'b0, bor: 1'b1, ext: 1'b0};
    localparam rst_cause_t CAUSE_EXT  = '{por: 1'b0, bor: 1'b0, ext: 1'b1};

    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

    // States in which a filtered supply dip is honoured
    function automatic logic dip_watched(input seq_state_e st);
        return (st == ST_OST_RUN) || (st == ST_WAIT_MCLR) || (st == ST_RUN);
    endfunction

endpackage

// File: rtl/rs_sync2.sv
module rs_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/rs_tick_timer.sv
module rs_tick_timer
    import rst_seq_pkg::*;
#(
    parameter int LEN = 72
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && tick_i && (cnt_q == LAST);

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CW'(LEN));
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/rs_dip_filter.sv
module rs_dip_filter
    import rst_seq_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic low_i,
    input  logic tick_i,
    output logic trip_o
);
    localparam int CW = cnt_width(LEN);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !arm_i || !low_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip_o = (cnt_q == FULL);

    p_trip_needs_low_r5: assert property (@(posedge clk) disable iff (rst)
        trip_o |-> $past(arm_i && low_i));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS     = 72,
    parameter int BOR_FILT_TICKS = 4,
    parameter int OST_TICKS      = 1024,
    parameter bit OST_BYPASS     = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_pulse_i,
    input  logic       supply_ok_i,
    input  logic       ext_rst_n_i,
    input  logic       cfg_pwrt_en_i,
    input  logic       cfg_bor_en_i,
    input  logic [1:0] cfg_trip_sel_i,
    input  logic       slow_tick_i,
    input  logic       osc_tick_i,
    output logic       core_rst_o,
    output logic [1:0] trip_sel_o,
    output logic       stat_por_o,
    output logic       stat_bor_o,
    output logic       stat_ext_o
);
    seq_state_e state_q, state_d;
    rst_cause_t cause_q, cause_d;

    logic pin_ok;
    logic pwrt_done;
    logic ost_done;
    logic dip_trip;
    logic supply_low;

    assign supply_low = cfg_bor_en_i && !supply_ok_i;

    rs_sync2 #(.RST_VAL(1'b0)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_rst_n_i),
        .q_o (pin_ok)
    );

    rs_tick_timer #(.LEN(PWRT_TICKS)) u_pwrt (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state_q == ST_PWRT_RUN),
        .tick_i (slow_tick_i),
        .done_o (pwrt_done)
    );

    generate
        if (OST_BYPASS) begin : g_no_ost
            logic unused_osc_tick;
            assign unused_osc_tick = osc_tick_i;
            assign ost_done = 1'b0;
        end else begin : g_ost
            rs_tick_timer #(.LEN(OST_TICKS)) u_ost (
                .clk    (clk),
                .rst    (rst),
                .run_i  (state_q == ST_OST_RUN),
                .tick_i (osc_tick_i),
                .done_o (ost_done)
            );
        end
    endgenerate

    rs_dip_filter #(.LEN(BOR_FILT_TICKS)) u_dip (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (cfg_bor_en_i && dip_watched(state_q)),
        .low_i  (!supply_ok_i),
        .tick_i (slow_tick_i),
        .trip_o (dip_trip)
    );

    function automatic seq_state_e after_ost(input logic pin_high);
        return pin_high ? ST_RUN : ST_WAIT_MCLR;
    endfunction

    function automatic seq_state_e after_pwrt(input logic pin_high);
        return OST_BYPASS ? after_ost(pin_high) : ST_OST_RUN;
    endfunction

    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        if (por_pulse_i) begin
            cause_d = CAUSE_POR;
            state_d = cfg_pwrt_en_i ? ST_PWRT_RUN : after_pwrt(pin_ok);
        end else begin
            unique case (state_q)
                ST_POR_WAIT: state_d = ST_POR_WAIT;
                ST_BOR_HOLD: begin
                    if (!supply_low) state_d = ST_PWRT_RUN;
                end
                ST_PWRT_RUN: begin
                    if (supply_low) begin
                        state_d = ST_BOR_HOLD;
                        cause_d = CAUSE_BOR;
                    end else if (pwrt_done) begin
                        state_d = after_pwrt(pin_ok);
                    end
                end
                ST_OST_RUN: begin
                    if (dip_trip) begin
                        state_d = ST_BOR_HOLD;
                        cause_d = CAUSE_BOR;
                    end else if (ost_done) begin
                        state_d = after_ost(pin_ok);
                    end
                end
                ST_WAIT_MCLR: begin
                    if (dip_trip) begin
                        state_d = ST_BOR_HOLD;
                        cause_d = CAUSE_BOR;
                    end else if (pin_ok) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (dip_trip) begin
                        state_d = ST_BOR_HOLD;
                        cause_d = CAUSE_BOR;
                    end else if (!pin_ok) begin
                        state_d = ST_WAIT_MCLR;
                        cause_d = CAUSE_EXT;
                    end
                end
                default: state_d = ST_POR_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POR_WAIT;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    assign core_rst_o = (state_q != ST_RUN);
    assign trip_sel_o = cfg_trip_sel_i;
    assign stat_por_o = cause_q.por;
    assign stat_bor_o = cause_q.bor;
    assign stat_ext_o = cause_q.ext;

    p_por_flags_r11: assert property (@(posedge clk) disable iff (rst)
        por_pulse_i |=> (stat_por_o && !stat_bor_o && !stat_ext_o));
    p_flags_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stat_por_o, stat_bor_o, stat_ext_o}));
    p_release_pin_r9: assert property (@(posedge clk) disable iff (rst)
        !core_rst_o |-> $past(pin_ok));
    p_pwrt_dip_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PWRT_RUN && !por_pulse_i && supply_low)
        |=> (state_q == ST_BOR_HOLD));
    p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOR_HOLD && !por_pulse_i && supply_low) |=> core_rst_o);
endmodule

// File: tb/rst_seq_top_test.sv
module rst_seq_top_test;
    localparam int P = 5;
    localparam int F = 3;
    localparam int O = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       por = 1'b0;
    logic       sup = 1'b1;
    logic       pin = 1'b1;
    logic       pwrt_en = 1'b1;
    logic       bor_en = 1'b0;
    logic [1:0] trip = 2'd0;
    logic       stk = 1'b0;
    logic       otk = 1'b0;

    logic       crst, crst_rc;
    logic [1:0] tsel, tsel_rc;
    logic       sp, sb, se, sp_rc, sb_rc, se_rc;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rst_seq_top #(.PWRT_TICKS(P), .BOR_FILT_TICKS(F), .OST_TICKS(O), .OST_BYPASS(1'b0)) uut (
        .clk(clk), .rst(rst), .por_pulse_i(por), .supply_ok_i(sup), .ext_rst_n_i(pin),
        .cfg_pwrt_en_i(pwrt_en), .cfg_bor_en_i(bor_en), .cfg_trip_sel_i(trip),
        .slow_tick_i(stk), .osc_tick_i(otk), .core_rst_o(crst), .trip_sel_o(tsel),
        .stat_por_o(sp), .stat_bor_o(sb), .stat_ext_o(se));

    rst_seq_top #(.PWRT_TICKS(P), .BOR_FILT_TICKS(F), .OST_TICKS(O), .OST_BYPASS(1'b1)) uut_rc (
        .clk(clk), .rst(rst), .por_pulse_i(por), .supply_ok_i(sup), .ext_rst_n_i(pin),
        .cfg_pwrt_en_i(pwrt_en), .cfg_bor_en_i(bor_en), .cfg_trip_sel_i(trip),
        .slow_tick_i(stk), .osc_tick_i(otk), .core_rst_o(crst_rc), .trip_sel_o(tsel_rc),
        .stat_por_o(sp_rc), .stat_bor_o(sb_rc), .stat_ext_o(se_rc));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            stk = 1'b1; otk = 1'b1;
            cyc();
        end
        stk = 1'b0; otk = 1'b0;
    endtask

    task automatic measure(input int gap, output int tm, output int tr);
        int ticks;
        ticks = 0; tm = -1; tr = -1;
        for (int i = 0; i < 4000; i++) begin
            if (!crst && tm < 0) tm = ticks;
            if (!crst_rc && tr < 0) tr = ticks;
            if (tm >= 0 && tr >= 0) break;
            stk = ((i % gap) == gap - 1);
            otk = stk;
            cyc();
            if (stk) ticks++;
        end
        stk = 1'b0; otk = 1'b0;
    endtask

    task automatic por_cycle();
        por = 1'b1; stk = 1'b0; otk = 1'b0;
        cyc();
        por = 1'b0;
    endtask

    task automatic enter_bor();
        sup = 1'b0;
        tick_cycles(F);
        cyc(); cyc();
    endtask

    initial begin
        #1200000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int tm, tr;
        @(negedge clk);
        cyc(); cyc();
        rst = 1'b0;
        cyc();

        // R1: reset state, no progress without power-on
        chk("R1 core_rst", crst, 1);
        chk("R1 flags", {sp, sb, se}, 0);
        tick_cycles(P + O + 3);
        chk("R1 waits for por", crst, 1);

        // R2/R3/R4: sweep timer enable and tick spacing
        for (int en = 0; en < 2; en++) begin
            for (int gap = 1; gap <= 3; gap++) begin
                pwrt_en = en[0];
                por_cycle();
                measure(gap, tm, tr);
                chk(en ? "R2 pwrt+ost ticks" : "R3 ost only ticks", tm, (en ? P : 0) + O);
                chk("R4 bypass ticks", tr, en ? P : 0);
            end
        end
        // R11: power-on flags
        chk("R11 por flags", {sp, sb, se}, 3'b100);

        // R12: trip select passes through
        for (int t = 0; t < 4; t++) begin
            trip = t[1:0];
            cyc();
            chk("R12 trip_sel", tsel, t);
        end

        // R6: brown-out disabled ignores supply
        bor_en = 1'b0; sup = 1'b0;
        tick_cycles(3 * F);
        cyc();
        chk("R6 no reset", crst, 0);
        chk("R6 no bor flag", sb, 0);
        sup = 1'b1;
        cyc();

        // R5: short dips ignored, full dip trips
        bor_en = 1'b1;
        for (int k = 1; k < F; k++) begin
            sup = 1'b0;
            tick_cycles(k);
            sup = 1'b1;
            cyc(); cyc(); cyc();
            chk("R5 short dip ignored", crst, 0);
        end
        pwrt_en = 1'b0;
        enter_bor();
        chk("R5 dip reset", crst, 1);
        chk("R11 bor flags", {sp, sb, se}, 3'b010);

        // R7: hold while low, then pwrt always applied
        tick_cycles(P + O + 2);
        chk("R7 held while low", crst, 1);
        sup = 1'b1;
        cyc();
        measure(1, tm, tr);
        chk("R7 recovery ticks", tm, P + O);

        // R8: dip during power-up timer restarts it
        enter_bor();
        sup = 1'b1;
        cyc();
        tick_cycles(P - 2);
        sup = 1'b0;
        cyc();
        chk("R8 back to hold", crst, 1);
        sup = 1'b1;
        cyc();
        measure(1, tm, tr);
        chk("R8 restarted ticks", tm, P + O);

        // R9: pin reset in run state
        pin = 1'b0;
        cyc(); cyc();
        chk("R9 two edges still run", crst, 0);
        cyc();
        chk("R9 third edge reset", crst, 1);
        chk("R9 ext flag", {sp, sb, se}, 3'b001);
        pin = 1'b1;
        cyc(); cyc();
        chk("R9 still held", crst, 1);
        cyc();
        chk("R9 release no timers", crst, 0);

        // R10: pin held low across a full power-on
        pwrt_en = 1'b1;
        pin = 1'b0;
        por_cycle();
        tick_cycles(P + O + 4);
        chk("R10 held by pin", crst, 1);
        pin = 1'b1;
        cyc(); cyc();
        chk("R10 two edges", crst, 1);
        cyc();
        chk("R10 release third edge", crst, 0);
        chk("R10 bypass release", crst_rc, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule